// File: doc/BRIEF.md
# Hierarchical configuration word loader

The loader sits between a configuration host (a processor or a flash reader) and the configuration storage of a programmable fabric built as a grid of tree-shaped logic nodes joined by switch boxes. The host presents one word at a time, made of an address and a data field. The loader splits the address into fields, most significant first. These are a component-class code, a node or box index, one slave field for each tree level above the leaves (the highest level first), an element-type field and an element index. It then issues a single one-cycle write strobe to the addressed register bank, with the data held on a shared registered bus.

Selection is gated one stage at a time. The class decode enables either the tree decoder or one of the box decoders. The node match enables the slave-path check. Each level's slave field must be in range before the next level is considered. The element-type and element-index match comes last. An address that fails any stage produces no strobe and raises a one-cycle error pulse. Words are accepted only while the loader select input is high.

Top module: `cfg_addr_loader`

## Requirements
- R1: A synchronous reset clears every write strobe, the error pulse and the data bus to zero.
- R2: `host_ready` is high only while `ld_sel` is 1 and the loader is not in the cycle that follows an accepted word. With `ld_sel` at 0 no word is accepted and no strobe or error appears.
- R3: Address fields from the top are: class (3 bits), index (2), one 2-bit slave field per level from the highest to level 0, type (bits 3:2) and element index (bits 1:0). Class 000 targets a tree node. Types are 00 logic block, 01 upward mux box and 10 downward mux box. Tree strobe number = (node·LEAVES + leaf)·12 + type·4 + index, where leaf is built from the slave fields taken high to low in base ARITY. For example, address 0000100001000 with data 01000111 drives tree strobe 116.
- R4: Class 001 selects core switch boxes, 010 exterior switch boxes, 011 the medium switch box and 100 the output mux boxes. The box strobe number is box·8 + (0 for upward, 4 for downward) + index.
- R5: Each accepted, valid word asserts exactly one strobe for exactly one cycle, starting the cycle after acceptance. During that cycle `cfg_data` equals the accepted data.
- R6: Element type 11, or a class code from 101 to 111, produces no strobe and a one-cycle `cfg_err` pulse.
- R7: A tree slave field at or above ARITY, a box index at or above that class's box count, or an element index at or above the count for its type produces no strobe and a one-cycle error pulse.
- R8: For box classes the slave fields must be zero, and only up/down types are allowed. Output mux boxes take only the downward type. Any other combination raises the error pulse with no strobe.
- R9: Every accepted word yields exactly one outcome in the next cycle, either one strobe or one error pulse, never both.
- R10: `host_ready` is low in the cycle right after each accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_sel | input | 1 | Loader select; words are decoded only while 1 |
| host_valid | input | 1 | Host word valid |
| host_ready | output | 1 | Loader can accept a word |
| host_addr | input | ADDR_W (13) | Configuration address |
| host_data | input | DATA_W (8) | Configuration data |
| cfg_data | output | DATA_W (8) | Registered data shared by all targets |
| tree_wr | output | TREE_W (432) | Tree element write strobes |
| core_wr | output | CORE_W (32) | Core switch box write strobes |
| ext_wr | output | EXT_W (32) | Exterior switch box write strobes |
| med_wr | output | MED_W (8) | Medium switch box write strobes |
| obox_wr | output | OBOX_W (32) | Output mux box write strobes |
| cfg_err | output | 1 | One-cycle pulse for a rejected address |

## Verification
The assertions assume the host follows the valid/ready rule, so a word counts only in a cycle where both are high. They also assume that `host_data` is sampled on that same edge, and that `rst` is synchronous. The stimulus changes inputs only on falling clock edges. Directed words wait for `host_ready` before raising valid. Random traffic may hold valid across a ready-low cycle or toggle `ld_sel`, which the bench's own acceptance model follows. Random addresses mix legal and illegal classes, types, slave fields and indices, so both strobe and error outcomes are seen under many select patterns.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam int CLASS_W   = 3;
  localparam int FIELD_W   = 2;
  localparam int PER_TYPE  = 4;
  localparam int TREE_SLOT = 3 * PER_TYPE;
  localparam int BOX_SLOT  = 2 * PER_TYPE;

  typedef enum logic [2:0] {
    CLS_TREE = 3'd0,
    CLS_CORE = 3'd1,
    CLS_EXT  = 3'd2,
    CLS_MED  = 3'd3,
    CLS_OBOX = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    EL_LOGIC = 2'd0,
    EL_UP    = 2'd1,
    EL_DOWN  = 2'd2,
    EL_RSVD  = 2'd3
  } elem_e;

  // Type/index legality against per-type population counts.
  function automatic logic elem_in_range(input logic [1:0] typ, input logic [1:0] idx,
                                         input int lb_cnt, input int up_cnt, input int dn_cnt);
    case (elem_e'(typ))
      EL_LOGIC: return int'(idx) < lb_cnt;
      EL_UP:    return int'(idx) < up_cnt;
      EL_DOWN:  return int'(idx) < dn_cnt;
      default:  return 1'b0;
    endcase
  endfunction

  // Slot of an element inside one tree leaf.
  function automatic int tree_elem_slot(input logic [1:0] typ, input logic [1:0] idx);
    return int'(typ) * PER_TYPE + int'(idx);
  endfunction

  // Slot of an element inside one switch box.
  function automatic int box_elem_slot(input logic [1:0] typ, input logic [1:0] idx);
    return ((typ == EL_UP) ? 0 : PER_TYPE) + int'(idx);
  endfunction

endpackage

// File: rtl/cfgld_class_dec.sv
module cfgld_class_dec (
  input  logic       en,
  input  logic [2:0] cls,
  output logic [4:0] cls_hit,
  output logic       cls_bad
);
  for (genvar k = 0; k < 5; k++) begin : g_cls
    assign cls_hit[k] = en && (cls == 3'(k));
  end
  assign cls_bad = en && (cls > 3'd4);
endmodule

// File: rtl/cfgld_tree_dec.sv
module cfgld_tree_dec #(
  parameter int N_NODES = 4,
  parameter int LEVELS  = 3,
  parameter int ARITY   = 3,
  parameter int LB_CNT  = 4,
  parameter int UP_CNT  = 2,
  parameter int DN_CNT  = 4,
  localparam int NSF    = LEVELS - 1,
  localparam int LEAVES = ARITY ** NSF,
  localparam int HIT_W  = N_NODES * LEAVES * cfgld_pkg::TREE_SLOT
) (
  input  logic              en,
  input  logic [1:0]        node,
  input  logic [2*NSF-1:0]  slv,
  input  logic [1:0]        typ,
  input  logic [1:0]        idx,
  output logic [HIT_W-1:0]  hit,
  output logic              bad
);
  localparam int TS = cfgld_pkg::TREE_SLOT;

  // stage 1: node select
  logic [N_NODES-1:0] node_sel;
  for (genvar n = 0; n < N_NODES; n++) begin : g_node
    assign node_sel[n] = en && (node == 2'(n));
  end

  // stage 2: slave path, highest level first, each gated by the one above
  logic [NSF:0] path_ok;
  logic [15:0]  leaf_acc [NSF+1];
  assign path_ok[0]  = |node_sel;
  assign leaf_acc[0] = '0;
  for (genvar l = 0; l < NSF; l++) begin : g_lvl
    logic [1:0] fld;
    assign fld           = slv[2*(NSF-l)-1 -: 2];
    assign path_ok[l+1]  = path_ok[l] && (32'(fld) < ARITY);
    assign leaf_acc[l+1] = leaf_acc[l] * 16'(ARITY) + 16'(fld);
  end

  // stage 3: element type and index
  logic elem_ok, go;
  assign elem_ok = cfgld_pkg::elem_in_range(typ, idx, LB_CNT, UP_CNT, DN_CNT);
  assign go      = path_ok[NSF] && elem_ok;
  assign bad     = en && !go;

  logic [TS-1:0]     elem_sel;
  logic [LEAVES-1:0] leaf_sel;
  for (genvar e = 0; e < TS; e++) begin : g_el
    assign elem_sel[e] = (cfgld_pkg::tree_elem_slot(typ, idx) == e);
  end
  for (genvar f = 0; f < LEAVES; f++) begin : g_leaf
    assign leaf_sel[f] = (leaf_acc[NSF] == 16'(f));
  end

  for (genvar n = 0; n < N_NODES; n++) begin : g_hn
    for (genvar f = 0; f < LEAVES; f++) begin : g_hl
      for (genvar e = 0; e < TS; e++) begin : g_he
        assign hit[(n*LEAVES + f)*TS + e] = go && node_sel[n] && leaf_sel[f] && elem_sel[e];
      end
    end
  end
endmodule

// File: rtl/cfgld_box_dec.sv
module cfgld_box_dec #(
  parameter int N_BOX  = 4,
  parameter int UP_CNT = 2,
  parameter int DN_CNT = 4,
  localparam int HIT_W = N_BOX * cfgld_pkg::BOX_SLOT
) (
  input  logic             en,
  input  logic [1:0]       box,
  input  logic             slv_nz,
  input  logic [1:0]       typ,
  input  logic [1:0]       idx,
  output logic [HIT_W-1:0] hit,
  output logic             bad
);
  localparam int BS = cfgld_pkg::BOX_SLOT;

  logic [N_BOX-1:0] box_sel;
  for (genvar b = 0; b < N_BOX; b++) begin : g_box
    assign box_sel[b] = en && (box == 2'(b));
  end

  logic go;
  assign go  = (|box_sel) && !slv_nz && cfgld_pkg::elem_in_range(typ, idx, 0, UP_CNT, DN_CNT);
  assign bad = en && !go;

  logic [BS-1:0] elem_sel;
  for (genvar e = 0; e < BS; e++) begin : g_el
    assign elem_sel[e] = (cfgld_pkg::box_elem_slot(typ, idx) == e);
  end

  for (genvar b = 0; b < N_BOX; b++) begin : g_hb
    for (genvar e = 0; e < BS; e++) begin : g_he
      assign hit[b*BS + e] = go && box_sel[b] && elem_sel[e];
    end
  end
endmodule

// File: rtl/cfg_addr_loader.sv
module cfg_addr_loader #(
  parameter int DATA_W      = 8,
  parameter int N_NODES     = 4,
  parameter int TREE_LEVELS = 3,
  parameter int ARITY       = 3,
  parameter int LB_PER_LEAF = 4,
  parameter int UP_PER_LEAF = 2,
  parameter int DN_PER_LEAF = 4,
  parameter int N_CORE_SB   = 4,
  parameter int N_EXT_SB    = 4,
  parameter int N_MED_SB    = 1,
  parameter int N_OUT_BOX   = 4,
  parameter int SB_UP       = 2,
  parameter int SB_DN       = 4,
  parameter int OBOX_DN     = 4,
  localparam int NSF    = TREE_LEVELS - 1,
  localparam int ADDR_W = cfgld_pkg::CLASS_W + cfgld_pkg::FIELD_W * (NSF + 3),
  localparam int LEAVES = ARITY ** NSF,
  localparam int TREE_W = N_NODES * LEAVES * cfgld_pkg::TREE_SLOT,
  localparam int CORE_W = N_CORE_SB * cfgld_pkg::BOX_SLOT,
  localparam int EXT_W  = N_EXT_SB * cfgld_pkg::BOX_SLOT,
  localparam int MED_W  = N_MED_SB * cfgld_pkg::BOX_SLOT,
  localparam int OBOX_W = N_OUT_BOX * cfgld_pkg::BOX_SLOT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_sel,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  output logic [DATA_W-1:0] cfg_data,
  output logic [TREE_W-1:0] tree_wr,
  output logic [CORE_W-1:0] core_wr,
  output logic [EXT_W-1:0]  ext_wr,
  output logic [MED_W-1:0]  med_wr,
  output logic [OBOX_W-1:0] obox_wr,
  output logic              cfg_err
);
  // ---- address fields
  logic [2:0]       f_cls;
  logic [1:0]       f_idx_hi, f_typ, f_idx;
  logic [2*NSF-1:0] f_slv;
  assign f_cls    = host_addr[ADDR_W-1 -: 3];
  assign f_idx_hi = host_addr[ADDR_W-4 -: 2];
  assign f_slv    = host_addr[4 +: 2*NSF];
  assign f_typ    = host_addr[3:2];
  assign f_idx    = host_addr[1:0];

  // ---- handshake events
  logic busy_q, accept;
  assign host_ready = ld_sel && !busy_q;
  assign accept     = host_valid && host_ready;

  // ---- class stage
  logic [4:0] cls_hit;
  logic       cls_bad;
  cfgld_class_dec u_cls (.en(accept), .cls(f_cls), .cls_hit(cls_hit), .cls_bad(cls_bad));

  // ---- target stages
  logic [TREE_W-1:0] tree_hit;
  logic [CORE_W-1:0] core_hit;
  logic [EXT_W-1:0]  ext_hit;
  logic [MED_W-1:0]  med_hit;
  logic [OBOX_W-1:0] obox_hit;
  logic tree_bad, core_bad, ext_bad, med_bad, obox_bad;
  logic slv_nz;
  assign slv_nz = |f_slv;

  cfgld_tree_dec #(
    .N_NODES(N_NODES), .LEVELS(TREE_LEVELS), .ARITY(ARITY),
    .LB_CNT(LB_PER_LEAF), .UP_CNT(UP_PER_LEAF), .DN_CNT(DN_PER_LEAF)
  ) u_tree (
    .en(cls_hit[cfgld_pkg::CLS_TREE]), .node(f_idx_hi), .slv(f_slv),
    .typ(f_typ), .idx(f_idx), .hit(tree_hit), .bad(tree_bad)
  );

  cfgld_box_dec #(.N_BOX(N_CORE_SB), .UP_CNT(SB_UP), .DN_CNT(SB_DN)) u_core (
    .en(cls_hit[cfgld_pkg::CLS_CORE]), .box(f_idx_hi), .slv_nz(slv_nz),
    .typ(f_typ), .idx(f_idx), .hit(core_hit), .bad(core_bad)
  );
  cfgld_box_dec #(.N_BOX(N_EXT_SB), .UP_CNT(SB_UP), .DN_CNT(SB_DN)) u_ext (
    .en(cls_hit[cfgld_pkg::CLS_EXT]), .box(f_idx_hi), .slv_nz(slv_nz),
    .typ(f_typ), .idx(f_idx), .hit(ext_hit), .bad(ext_bad)
  );
  cfgld_box_dec #(.N_BOX(N_MED_SB), .UP_CNT(SB_UP), .DN_CNT(SB_DN)) u_med (
    .en(cls_hit[cfgld_pkg::CLS_MED]), .box(f_idx_hi), .slv_nz(slv_nz),
    .typ(f_typ), .idx(f_idx), .hit(med_hit), .bad(med_bad)
  );
  cfgld_box_dec #(.N_BOX(N_OUT_BOX), .UP_CNT(0), .DN_CNT(OBOX_DN)) u_obox (
    .en(cls_hit[cfgld_pkg::CLS_OBOX]), .box(f_idx_hi), .slv_nz(slv_nz),
    .typ(f_typ), .idx(f_idx), .hit(obox_hit), .bad(obox_bad)
  );

  logic dec_err;
  assign dec_err = cls_bad | tree_bad | core_bad | ext_bad | med_bad | obox_bad;

  // ---- output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cfg_data <= '0;
      tree_wr  <= '0;
      core_wr  <= '0;
      ext_wr   <= '0;
      med_wr   <= '0;
      obox_wr  <= '0;
      cfg_err  <= 1'b0;
    end else begin
      busy_q  <= accept;
      tree_wr <= tree_hit;
      core_wr <= core_hit;
      ext_wr  <= ext_hit;
      med_wr  <= med_hit;
      obox_wr <= obox_hit;
      cfg_err <= dec_err;
      if (accept) cfg_data <= host_data;
    end
  end

  // ---- assertions
  logic any_wr;
  assign any_wr = (|tree_wr) | (|core_wr) | (|ext_wr) | (|med_wr) | (|obox_wr);

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !host_ready);
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tree_wr, core_wr, ext_wr, med_wr, obox_wr}));
  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    any_wr |=> !any_wr);
  // R5
  data_held_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (cfg_data == $past(host_data)));
  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !any_wr);
  // R9
  outcome_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (any_wr || cfg_err));
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (!any_wr && !cfg_err));
endmodule

// File: tb/cfg_addr_loader_test.sv
module cfg_addr_loader_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst, ld_sel, host_valid, host_ready, cfg_err;
  logic [12:0]  host_addr;
  logic [7:0]   host_data, cfg_data;
  logic [431:0] tree_wr;
  logic [31:0]  core_wr, ext_wr, obox_wr;
  logic [7:0]   med_wr;

  cfg_addr_loader uut (
    .clk(clk), .rst(rst), .ld_sel(ld_sel), .host_valid(host_valid), .host_ready(host_ready),
    .host_addr(host_addr), .host_data(host_data), .cfg_data(cfg_data), .tree_wr(tree_wr),
    .core_wr(core_wr), .ext_wr(ext_wr), .med_wr(med_wr), .obox_wr(obox_wr), .cfg_err(cfg_err)
  );

  int    n_checks = 0, n_fail = 0;
  bit    done = 0;
  string req_now = "R1";

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int first_set(input logic [431:0] v);
    for (int i = 0; i < 432; i++) if (v[i]) return i;
    return -1;
  endfunction

  // Behavioural decode: group 0 tree, 1 core, 2 ext, 3 med, 4 out box; -1 rejected
  function automatic void ref_decode(input logic [12:0] a, output int grp, output int idx);
    int cls, hi, s1, s0, ty, ix, nbox;
    cls = int'(a[12:10]); hi = int'(a[9:8]); s1 = int'(a[7:6]); s0 = int'(a[5:4]);
    ty = int'(a[3:2]); ix = int'(a[1:0]);
    grp = -1; idx = 0;
    if (cls == 0) begin
      if (s1 < 3 && s0 < 3 &&
          ((ty == 0 && ix < 4) || (ty == 1 && ix < 2) || (ty == 2 && ix < 4))) begin
        grp = 0;
        idx = hi * 108 + (s1 * 3 + s0) * 12 + ty * 4 + ix;
      end
    end else if (cls <= 4) begin
      nbox = (cls == 3) ? 1 : 4;
      if (s1 == 0 && s0 == 0 && hi < nbox) begin
        if (ty == 2 && ix < 4) begin grp = cls; idx = hi * 8 + 4 + ix; end
        else if (ty == 1 && ix < 2 && cls != 4) begin grp = cls; idx = hi * 8 + ix; end
      end
    end
  endfunction

  // Cycle reference model
  bit       m_busy;
  int       m_grp;
  bit       m_err;
  bit [7:0] m_data;
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_grp <= -1; m_err <= 0; m_data <= 0;
    end else if (host_valid && ld_sel && !m_busy) begin
      int g, i;
      ref_decode(host_addr, g, i);
      m_busy <= 1; m_grp <= (g < 0) ? -1 : g * 1000 + i; m_err <= (g < 0);
      m_data <= host_data;
    end else begin
      m_busy <= 0; m_grp <= -1; m_err <= 0;
    end
  end

  function automatic logic [431:0] grp_vec(input int g);
    case (g)
      0: return tree_wr;
      1: return 432'(core_wr);
      2: return 432'(ext_wr);
      3: return 432'(med_wr);
      default: return 432'(obox_wr);
    endcase
  endfunction

  logic [431:0] v_act, v_exp;
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int g = 0; g < 5; g++) begin
        v_act = grp_vec(g);
        v_exp = '0;
        if (m_grp >= 0 && m_grp / 1000 == g) v_exp[m_grp % 1000] = 1'b1;
        check(v_act == v_exp, req_now, $sformatf("group %0d strobe index", g),
              first_set(v_act), first_set(v_exp));
      end
      check(cfg_err == m_err, req_now, "cfg_err", int'(cfg_err), int'(m_err));
      check(host_ready == (ld_sel && !m_busy), req_now, "host_ready",
            int'(host_ready), int'(ld_sel && !m_busy));
      check(cfg_data == m_data, req_now, "cfg_data", int'(cfg_data), int'(m_data));
    end
  end

  function automatic logic [12:0] mk(input int cls, input int hi, input int s1, input int s0,
                                     input int ty, input int ix);
    return {3'(cls), 2'(hi), 2'(s1), 2'(s0), 2'(ty), 2'(ix)};
  endfunction

  // Returns at the falling edge where the outcome of the word is visible.
  task automatic send(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1; host_addr = a; host_data = d;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic expect_err(input logic [12:0] a, input string req);
    req_now = req;
    send(a, 8'hA5);
    check(cfg_err == 1'b1, req, "error pulse", int'(cfg_err), 1);
    check(first_set(tree_wr) == -1 && core_wr == 0 && ext_wr == 0 && med_wr == 0 && obox_wr == 0,
          req, "no strobe on rejected word", first_set(tree_wr), -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; ld_sel = 1; host_valid = 0; host_addr = '0; host_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(first_set(tree_wr) == -1 && core_wr == 0 && ext_wr == 0 && med_wr == 0 && obox_wr == 0,
          "R1", "strobes in reset", first_set(tree_wr), -1);
    check(cfg_err == 0, "R1", "error in reset", int'(cfg_err), 0);
    check(cfg_data == 0, "R1", "data in reset", int'(cfg_data), 0);
    rst = 0;

    // R3 worked example, node 1, downward box 0 of the first leaf
    req_now = "R3";
    send(13'b0000100001000, 8'b01000111);
    check(tree_wr[116] == 1'b1, "R3", "example strobe", first_set(tree_wr), 116);
    check(cfg_data == 8'h47, "R5", "data with strobe", int'(cfg_data), 'h47);
    check(host_ready == 1'b0, "R10", "ready after accept", int'(host_ready), 0);
    @(negedge clk);
    check(first_set(tree_wr) == -1, "R5", "strobe lasts one cycle", first_set(tree_wr), -1);
    check(host_ready == 1'b1, "R10", "ready returns", int'(host_ready), 1);

    send(mk(0, 3, 2, 1, 0, 3), 8'h11);
    check(tree_wr[411] == 1'b1, "R3", "logic block deep leaf", first_set(tree_wr), 411);
    send(mk(0, 2, 0, 2, 1, 1), 8'h22);
    check(tree_wr[245] == 1'b1, "R3", "upward box", first_set(tree_wr), 245);

    // R4 box classes
    req_now = "R4";
    send(mk(1, 2, 0, 0, 1, 1), 8'h33);
    check(core_wr[17] == 1'b1, "R4", "core box up", first_set(432'(core_wr)), 17);
    send(mk(2, 3, 0, 0, 2, 3), 8'h44);
    check(ext_wr[31] == 1'b1, "R4", "exterior box down", first_set(432'(ext_wr)), 31);
    send(mk(3, 0, 0, 0, 2, 2), 8'h55);
    check(med_wr[6] == 1'b1, "R4", "medium box down", first_set(432'(med_wr)), 6);
    send(mk(4, 1, 0, 0, 2, 0), 8'h66);
    check(obox_wr[12] == 1'b1, "R4", "output box down", first_set(432'(obox_wr)), 12);

    // R6 reserved codes
    expect_err(mk(0, 1, 0, 0, 3, 0), "R6");
    expect_err(mk(5, 0, 0, 0, 2, 0), "R6");
    expect_err(mk(7, 0, 0, 0, 1, 0), "R6");
    // R7 out of range
    expect_err(mk(0, 0, 3, 0, 2, 0), "R7");
    expect_err(mk(0, 0, 0, 0, 1, 2), "R7");
    expect_err(mk(3, 1, 0, 0, 2, 0), "R7");
    // R8 box field rules
    expect_err(mk(1, 0, 0, 1, 2, 0), "R8");
    expect_err(mk(4, 0, 0, 0, 1, 0), "R8");
    expect_err(mk(2, 0, 0, 0, 0, 0), "R8");

    // R2 select low: word held, nothing accepted
    req_now = "R2";
    @(negedge clk);
    ld_sel = 0; host_valid = 1; host_addr = mk(0, 0, 0, 0, 0, 0); host_data = 8'h77;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(host_ready == 0 && first_set(tree_wr) == -1 && cfg_err == 0, "R2",
            "no accept while deselected", first_set(tree_wr), -1);
    end
    ld_sel = 1;
    @(negedge clk);
    host_valid = 0;
    check(tree_wr[0] == 1'b1, "R2", "accepted once selected", first_set(tree_wr), 0);

    // R9 random traffic checked against the cycle model
    req_now = "R9";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      ld_sel     = ($urandom % 10) != 0;
      host_valid = $urandom % 2;
      host_addr  = {3'(($urandom % 6 == 5) ? 5 + $urandom % 3 : $urandom % 5), 10'($urandom)};
      if ($urandom % 2) host_addr[7:4] = 4'h0;
      host_data  = 8'($urandom);
    end
    @(negedge clk);
    host_valid = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule